// File: doc/BRIEF.md
# Bus Status Decoder and Command Generator

This block sits beside a processor that reports each bus transaction only through a 3-bit status code. It watches that code on every clock and turns it into separate command strobes: memory read, memory write, I/O read, I/O write, interrupt acknowledge and instruction fetch. It also pulses a start indication when a transaction opens and an end indication when it closes. A transaction opens when the status leaves the idle code 111, and it closes when the status is back at idle and ready is high. No explicit strobe from the processor is used.

The status and ready inputs are registered once. The block then compares the newest sampled code with the one sampled one clock before it. The kind of an open transaction is latched when its start is seen. One strobe is driven from that latched kind until the transaction closes. A float input takes all command strobes low at once, for the time another master owns the bus. The start and end indications are not affected by it.

Top module: `bsd_cmd_gen`

## Requirements
- R1: `cyc_start_o` is high for exactly one clock, in the clock after the first edge that samples a non-idle status (anything other than 111) where the edge before it sampled idle (111).
- R2: A transaction's kind picks its strobe by status code: 000 gives `iack_o`, 001 gives `io_rd_o`, 010 gives `io_wr_o`, 101 gives `mem_rd_o` and 110 gives `mem_wr_o`. At most one of `mem_rd_o`, `mem_wr_o`, `io_rd_o`, `io_wr_o` and `iack_o` is high at any time.
- R3: The strobe goes high in the clock after `cyc_start_o`. It stays high up to and including the clock in which `cyc_end_o` is high, and it is low in the clock after that.
- R4: `cyc_end_o` is high for one clock when, with a transaction open, an edge samples idle status together with ready high. `cyc_start_o` and `cyc_end_o` are never high together.
- R5: If idle status is sampled while ready is low, the transaction does not close. The strobe stays high and `cyc_end_o` stays low until idle and ready high are sampled on the same edge.
- R6: The halt code 011 opens and closes a transaction with start and end indications, but it drives no command strobe.
- R7: The code-access code 100 drives both `fetch_o` and `mem_rd_o`. `fetch_o` is never high without `mem_rd_o`.
- R8: While `float_i` is high, all six command strobes are low. `cyc_start_o` and `cyc_end_o` are unaffected by it.
- R9: A change from one non-idle code straight to another non-idle code is not a start. The latched kind, and therefore the strobe, stays as it was.
- R10: While `rst` is high, and in the first clock after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_stat_i | input | 3 | Processor bus status code |
| bus_ready_i | input | 1 | Transfer-complete acknowledge from the addressed device |
| float_i | input | 1 | Forces all command strobes inactive |
| mem_rd_o | output | 1 | Memory read command (also for code access) |
| mem_wr_o | output | 1 | Memory write command |
| io_rd_o | output | 1 | I/O read command |
| io_wr_o | output | 1 | I/O write command |
| iack_o | output | 1 | Interrupt acknowledge command |
| fetch_o | output | 1 | Instruction fetch qualifier |
| cyc_start_o | output | 1 | One-clock pulse when a transaction opens |
| cyc_end_o | output | 1 | One-clock pulse when a transaction closes |

## Verification
The bench sweeps every non-idle code with active phases of one to three clocks, with zero or one idle-but-not-ready clocks, and with float both off and on. It checks every output in every clock against a timeline worked out from the requirements. A design that closed on idle alone would raise `cyc_end_o` early and drop the strobe during the not-ready clock. A design that treated any change of status as a start would switch strobes when one non-idle code follows another, or raise a second start pulse. A single-clock active phase catches a strobe that runs one clock late. The halt and code-access codes catch a decoder that maps halt to a strobe or leaves out the fetch qualifier.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    localparam int STAT_W = 3;
    localparam int NCMD   = 6;

    typedef enum logic [STAT_W-1:0] {
        ST_IACK = 3'b000,
        ST_IORD = 3'b001,
        ST_IOWR = 3'b010,
        ST_HALT = 3'b011,
        ST_CODE = 3'b100,
        ST_MRD  = 3'b101,
        ST_MWR  = 3'b110,
        ST_IDLE = 3'b111
    } stat_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic iack;
        logic fetch;
    } cmd_t;

    function automatic logic is_idle(stat_e s);
        return s == ST_IDLE;
    endfunction

    function automatic cmd_t decode_cmd(stat_e s);
        cmd_t c;
        c = '0;
        case (s)
            ST_IACK: c.iack   = 1'b1;
            ST_IORD: c.io_rd  = 1'b1;
            ST_IOWR: c.io_wr  = 1'b1;
            ST_CODE: begin
                c.mem_rd = 1'b1;
                c.fetch  = 1'b1;
            end
            ST_MRD:  c.mem_rd = 1'b1;
            ST_MWR:  c.mem_wr = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsd_stat_pipe.sv
module bsd_stat_pipe
    import bsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] stat_i,
    input  logic              ready_i,
    output stat_e             cur_q,
    output stat_e             prv_q,
    output logic              rdy_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= ST_IDLE;
            prv_q <= ST_IDLE;
            rdy_q <= 1'b0;
        end else begin
            cur_q <= stat_e'(stat_i);
            prv_q <= cur_q;
            rdy_q <= ready_i;
        end
    end
endmodule

// File: rtl/bsd_cycle_track.sv
module bsd_cycle_track
    import bsd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_e cur_q,
    input  stat_e prv_q,
    input  logic  rdy_q,
    output logic  start_o,
    output logic  end_o,
    output logic  open_q,
    output stat_e kind_q
);
    assign start_o = is_idle(prv_q) && !is_idle(cur_q);
    assign end_o   = open_q && is_idle(cur_q) && rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            kind_q <= ST_IDLE;
        end else if (start_o) begin
            open_q <= 1'b1;
            kind_q <= cur_q;
        end else if (end_o) begin
            open_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bsd_cmd_drive.sv
module bsd_cmd_drive
    import bsd_pkg::*;
(
    input  logic  open_q,
    input  stat_e kind_q,
    input  logic  float_i,
    output cmd_t  cmd_o
);
    logic [NCMD-1:0] raw;
    logic [NCMD-1:0] gated;

    assign raw = decode_cmd(kind_q);

    for (genvar i = 0; i < NCMD; i++) begin : g_gate
        assign gated[i] = raw[i] & open_q & ~float_i;
    end

    assign cmd_o = cmd_t'(gated);
endmodule

// File: rtl/bsd_cmd_gen.sv
module bsd_cmd_gen
    import bsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] bus_stat_i,
    input  logic              bus_ready_i,
    input  logic              float_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              io_rd_o,
    output logic              io_wr_o,
    output logic              iack_o,
    output logic              fetch_o,
    output logic              cyc_start_o,
    output logic              cyc_end_o
);
    stat_e cur_q, prv_q, kind_q;
    logic  rdy_q, open_q;
    cmd_t  cmd;

    bsd_stat_pipe u_pipe (
        .clk(clk), .rst(rst), .stat_i(bus_stat_i), .ready_i(bus_ready_i),
        .cur_q(cur_q), .prv_q(prv_q), .rdy_q(rdy_q)
    );

    bsd_cycle_track u_track (
        .clk(clk), .rst(rst), .cur_q(cur_q), .prv_q(prv_q), .rdy_q(rdy_q),
        .start_o(cyc_start_o), .end_o(cyc_end_o), .open_q(open_q), .kind_q(kind_q)
    );

    bsd_cmd_drive u_drive (
        .open_q(open_q), .kind_q(kind_q), .float_i(float_i), .cmd_o(cmd)
    );

    assign mem_rd_o = cmd.mem_rd;
    assign mem_wr_o = cmd.mem_wr;
    assign io_rd_o  = cmd.io_rd;
    assign io_wr_o  = cmd.io_wr;
    assign iack_o   = cmd.iack;
    assign fetch_o  = cmd.fetch;
endmodule

// File: rtl/bsd_cmd_gen_chk.sv
module bsd_cmd_gen_chk (
    input logic clk,
    input logic rst,
    input logic float_i,
    input logic mem_rd_o,
    input logic mem_wr_o,
    input logic io_rd_o,
    input logic io_wr_o,
    input logic iack_o,
    input logic fetch_o,
    input logic cyc_start_o,
    input logic cyc_end_o
);
    logic [4:0] strobes;
    logic       any_cmd;
    assign strobes = {mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, iack_o};
    assign any_cmd = |strobes || fetch_o;

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes));

    assert_float_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        float_i |-> !any_cmd);

    assert_fetch_is_read_R7: assert property (@(posedge clk) disable iff (rst)
        fetch_o |-> mem_rd_o);

    assert_drop_after_end_R3: assert property (@(posedge clk) disable iff (rst)
        cyc_end_o |=> !any_cmd);

    assert_rise_after_start_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(any_cmd) && !float_i && !$past(float_i)) |-> $past(cyc_start_o));

    assert_start_end_apart_R4: assert property (@(posedge clk) disable iff (rst)
        !(cyc_start_o && cyc_end_o));
endmodule

bind bsd_cmd_gen bsd_cmd_gen_chk u_chk (
    .clk(clk), .rst(rst), .float_i(float_i),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .io_rd_o(io_rd_o),
    .io_wr_o(io_wr_o), .iack_o(iack_o), .fetch_o(fetch_o),
    .cyc_start_o(cyc_start_o), .cyc_end_o(cyc_end_o)
);

// File: tb/bsd_cmd_gen_test.sv
module bsd_cmd_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] stat = 3'b111;
    logic       rdy = 1'b1;
    logic       flt = 1'b0;
    logic mem_rd, mem_wr, io_rd, io_wr, iack, fetch, cstart, cend;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bsd_cmd_gen uut (
        .clk(clk), .rst(rst), .bus_stat_i(stat), .bus_ready_i(rdy), .float_i(flt),
        .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .io_rd_o(io_rd), .io_wr_o(io_wr),
        .iack_o(iack), .fetch_o(fetch), .cyc_start_o(cstart), .cyc_end_o(cend)
    );

    // {mem_rd, mem_wr, io_rd, io_wr, iack, fetch} expected for a code
    function automatic logic [5:0] want_cmd(input logic [2:0] code, input logic f);
        logic [5:0] w;
        case (code)
            3'b000: w = 6'b000010;
            3'b001: w = 6'b001000;
            3'b010: w = 6'b000100;
            3'b100: w = 6'b100001;
            3'b101: w = 6'b100000;
            3'b110: w = 6'b010000;
            default: w = 6'b000000;
        endcase
        return f ? 6'b0 : w;
    endfunction

    task automatic check(input string req, input logic [5:0] c, input logic s, input logic e);
        logic [7:0] act, exp;
        act = {mem_rd, mem_wr, io_rd, io_wr, iack, fetch, cstart, cend};
        exp = {c, s, e};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] s, input logic r);
        stat = s;
        rdy  = r;
        @(negedge clk);
    endtask

    // one transaction: nact clocks of code, npl clocks idle-not-ready, then close
    task automatic xact(input logic [2:0] code, input int nact, input int npl, input logic f);
        logic [5:0] w;
        w = want_cmd(code, f);
        flt = f;
        step(3'b111, 1'b1);
        step(3'b111, 1'b1);
        check("R10 idle", 6'b0, 1'b0, 1'b0);
        step(code, 1'b0);
        check("R1 start", 6'b0, 1'b1, 1'b0);
        for (int k = 1; k < nact; k++) begin
            step(code, 1'b0);
            check("R2 R6 R7 R8 strobe", w, 1'b0, 1'b0);
        end
        for (int k = 0; k < npl; k++) begin
            step(3'b111, 1'b0);
            check("R5 not ready", w, 1'b0, 1'b0);
        end
        step(3'b111, 1'b1);
        check("R4 end", w, 1'b0, 1'b1);
        step(3'b111, 1'b1);
        check("R3 drop", 6'b0, 1'b0, 1'b0);
        flt = 1'b0;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        stat = 3'b101;
        rst  = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 reset", 6'b0, 1'b0, 1'b0);
        rst = 1'b0;
        stat = 3'b111;
        @(negedge clk);
        check("R10 after reset", 6'b0, 1'b0, 1'b0);

        for (int c = 0; c < 7; c++)
            for (int f = 0; f < 2; f++)
                for (int na = 1; na <= 3; na++)
                    for (int np = 0; np < 2; np++)
                        xact(3'(c), na, np, f[0]);

        // R9: memory read then memory write without idle between
        step(3'b111, 1'b1);
        step(3'b111, 1'b1);
        step(3'b101, 1'b0);
        check("R9 start", 6'b0, 1'b1, 1'b0);
        step(3'b101, 1'b0);
        check("R9 read", 6'b100000, 1'b0, 1'b0);
        step(3'b110, 1'b0);
        check("R9 switch", 6'b100000, 1'b0, 1'b0);
        step(3'b110, 1'b0);
        check("R9 held", 6'b100000, 1'b0, 1'b0);
        step(3'b111, 1'b1);
        check("R9 end", 6'b100000, 1'b0, 1'b1);
        step(3'b111, 1'b1);
        check("R9 drop", 6'b0, 1'b0, 1'b0);

        // R8: float raised mid-transaction, start/end unaffected
        step(3'b010, 1'b0);
        check("R8 start", 6'b0, 1'b1, 1'b0);
        step(3'b010, 1'b0);
        check("R8 io write", 6'b000100, 1'b0, 1'b0);
        flt = 1'b1;
        step(3'b111, 1'b1);
        check("R8 float end", 6'b0, 1'b0, 1'b1);
        flt = 1'b0;
        step(3'b111, 1'b1);
        check("R8 drop", 6'b0, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule